// File: doc/BRIEF.md
# Bubble Sort Memory Controller

This block takes control of the single port of a synchronous RAM and sorts a block of sixteen unsigned 8-bit values kept at addresses 0 to 15. It first reads the whole block into a local register array, then sorts that array in place with adjacent compare-and-exchange passes, and finally streams the ordered values back to the same addresses. It then parks in an end state with its done flag raised.

Leaving reset starts a sort at once. A one-cycle start pulse given in the end state runs the whole sequence again on whatever the RAM holds at that moment. The RAM returns read data one cycle after it samples an address. The controller keeps the RAM enable high at all times and raises write enable only while it writes the results back.

Top module: `bubble_sort_engine`

## Requirements
- R1: Reset is synchronous and active high. While it is applied and in the first cycle after it is released, mem_addr is 0, mem_en is 1, mem_we is 0 and done is 0. A reset applied in the middle of a run abandons that run and starts a fresh load.
- R2: The load phase presents addresses 0, 1, ..., 15 on sixteen consecutive cycles. It starts with the first cycle after reset release, or the first cycle after a restart.
- R3: The RAM returns data one cycle after the address. The value on mem_rdata in the cycle after address k was presented becomes element k, so the load phase lasts 17 cycles.
- R4: The written-back block holds the same values as the input, in non-decreasing unsigned order with the smallest at address 0. For example, 0x80 is placed after 0x7F.
- R5: Write-back lasts 16 consecutive cycles with mem_we = 1. The addresses rise from 0 to 15 and mem_wdata is the k-th smallest value at address k. done rises in the cycle after address 15 is written.
- R6: mem_we is 0 in every cycle outside write-back, and no address above 15 is ever written.
- R7: Pass p (counting from 0) compares 15 - p adjacent pairs at one pair per cycle. Sorting stops after the first pass that makes no exchange, or after pass 14. done first appears 33 + (total compares) cycles after cycle 0: at cycle 48 for sorted input and at cycle 153 for strictly descending input.
- R8: done is 1 only in the end state. It stays 1 until a start pulse arrives. A start pulse given outside the end state has no effect.
- R9: A start pulse in the end state drops done in the next cycle and begins a new load from address 0.
- R10: Equal neighbours are never exchanged. A block of identical values therefore finishes after a single pass, with done at cycle 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart pulse, honoured only in the end state |
| mem_en | output | 1 | RAM enable, held high |
| mem_we | output | 1 | RAM write enable, high only during write-back |
| mem_addr | output | 8 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after the address |
| done | output | 1 | High in the end state |

## Verification
Strictly descending input forces all fifteen passes. A design that drops the last pass, or exits early, leaves the two smallest values out of order and finishes before cycle 153. Already sorted input and all-equal input must both finish at cycle 48. A design that exchanged equal values, or ignored the no-exchange exit, would run extra passes and miss that cycle. A block mixing 0x00, 0x7F, 0x80 and 0xFF exposes a signed compare, which would place 0x80 and 0xFF first. An off-by-one in the capture latency shows up as every value shifted by one address. A start pulse injected mid-sort must not disturb the cycle count, and a reset applied mid-run must restart the load cleanly.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    localparam int unsigned DEF_COUNT  = 16;
    localparam int unsigned DEF_WIDTH  = 8;
    localparam int unsigned DEF_ADDR_W = 8;

    typedef enum logic [1:0] {
        PH_LOAD  = 2'd0,
        PH_SORT  = 2'd1,
        PH_WRITE = 2'd2,
        PH_END   = 2'd3
    } phase_e;

    // index width for an array of n entries, at least one bit
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bsort_compare.sv
module bsort_compare #(
    parameter int unsigned WIDTH = bsort_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] lo_val,
    input  logic [WIDTH-1:0] hi_val,
    output logic             out_of_order
);

    // strict unsigned compare: equal neighbours stay put (stable order)
    assign out_of_order = lo_val > hi_val;

endmodule

// File: rtl/bsort_regfile.sv
module bsort_regfile #(
    parameter int unsigned COUNT = bsort_pkg::DEF_COUNT,
    parameter int unsigned WIDTH = bsort_pkg::DEF_WIDTH,
    localparam int unsigned IW   = bsort_pkg::idx_bits(COUNT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [IW-1:0]    cap_idx,
    input  logic [WIDTH-1:0] cap_data,
    input  logic             swap_en,
    input  logic [IW-1:0]    swap_idx,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] lo_val,
    output logic [WIDTH-1:0] hi_val,
    output logic [WIDTH-1:0] rd_val
);

    logic [WIDTH-1:0] slot_q [COUNT];
    logic [IW-1:0]    hi_pos;

    assign hi_pos = swap_idx + 1'b1;
    assign lo_val = slot_q[swap_idx];
    assign hi_val = slot_q[hi_pos];
    assign rd_val = slot_q[rd_idx];

    for (genvar i = 0; i < COUNT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (cap_en && cap_idx == IW'(i)) begin
                slot_q[i] <= cap_data;
            end else if (swap_en && swap_idx == IW'(i)) begin
                slot_q[i] <= hi_val;
            end else if (swap_en && hi_pos == IW'(i)) begin
                slot_q[i] <= lo_val;
            end
        end
    end

    // an exchange moves the upper value down and the lower value up
    assert_swap_exchanges_R4: assert property (@(posedge clk) disable iff (rst)
        swap_en |=> (slot_q[$past(swap_idx)] == $past(hi_val)) &&
                    (slot_q[$past(hi_pos)]   == $past(lo_val)));

endmodule

// File: rtl/bsort_sequencer.sv
module bsort_sequencer
    import bsort_pkg::*;
#(
    parameter int unsigned COUNT  = DEF_COUNT,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    localparam int unsigned IW    = idx_bits(COUNT),
    localparam int unsigned CW    = IW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              out_of_order,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_active,
    output logic              cap_en,
    output logic [IW-1:0]     cap_idx,
    output logic [IW-1:0]     cmp_idx,
    output logic [IW-1:0]     wr_idx,
    output logic              swap_en,
    output logic              done
);

    typedef struct packed {
        logic [IW-1:0] pass;
        logic [IW-1:0] pos;
        logic          dirty;
    } cursor_t;

    localparam logic [CW-1:0]     LOAD_LAST  = CW'(COUNT);
    localparam logic [CW-1:0]     ISSUE_LAST = CW'(COUNT - 1);
    localparam logic [IW-1:0]     PASS_LAST  = IW'(COUNT - 2);
    localparam logic [ADDR_W-1:0] ADDR_LAST  = ADDR_W'(COUNT - 1);

    phase_e            st_q;
    logic [CW-1:0]     cnt_q;
    logic [ADDR_W-1:0] addr_q;
    cursor_t           cur_q;

    logic [IW-1:0] pos_last;
    logic          pass_end;
    logic          quit;

    assign pos_last = PASS_LAST - cur_q.pass;
    assign pass_end = cur_q.pos == pos_last;
    assign quit     = !(cur_q.dirty || out_of_order) || (cur_q.pass == PASS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PH_LOAD;
            cnt_q  <= '0;
            addr_q <= '0;
            cur_q  <= '0;
        end else begin
            unique case (st_q)
                PH_LOAD: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q < ISSUE_LAST) addr_q <= addr_q + 1'b1;
                    else                    addr_q <= '0;
                    if (cnt_q == LOAD_LAST) begin
                        st_q  <= PH_SORT;
                        cnt_q <= '0;
                        cur_q <= '0;
                    end
                end
                PH_SORT: begin
                    if (pass_end) begin
                        if (quit) begin
                            st_q <= PH_WRITE;
                        end else begin
                            cur_q.pass  <= cur_q.pass + 1'b1;
                            cur_q.pos   <= '0;
                            cur_q.dirty <= 1'b0;
                        end
                    end else begin
                        cur_q.pos   <= cur_q.pos + 1'b1;
                        cur_q.dirty <= cur_q.dirty | out_of_order;
                    end
                end
                PH_WRITE: begin
                    if (addr_q == ADDR_LAST) begin
                        addr_q <= '0;
                        st_q   <= PH_END;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                PH_END: begin
                    if (start) begin
                        st_q   <= PH_LOAD;
                        cnt_q  <= '0;
                        addr_q <= '0;
                    end
                end
                default: st_q <= PH_LOAD;
            endcase
        end
    end

    assign addr      = addr_q;
    assign wr_active = st_q == PH_WRITE;
    assign cap_en    = (st_q == PH_LOAD) && (cnt_q != '0);
    assign cap_idx   = IW'(cnt_q - 1'b1);
    assign cmp_idx   = cur_q.pos;
    assign wr_idx    = addr_q[IW-1:0];
    assign swap_en   = (st_q == PH_SORT) && out_of_order;
    assign done      = st_q == PH_END;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (st_q == PH_LOAD) && (addr_q == '0) && (cnt_q == '0));

    assert_wb_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_WRITE && addr_q != ADDR_LAST) |=> addr_q == $past(addr_q) + 1'b1);

    assert_done_follows_wb_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(st_q) == PH_WRITE) && ($past(addr_q) == ADDR_LAST));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_restart_load_R9: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done && (st_q == PH_LOAD) && (addr_q == '0));

endmodule

// File: rtl/bubble_sort_engine.sv
module bubble_sort_engine #(
    parameter int unsigned COUNT  = bsort_pkg::DEF_COUNT,
    parameter int unsigned WIDTH  = bsort_pkg::DEF_WIDTH,
    parameter int unsigned ADDR_W = bsort_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WIDTH-1:0]  mem_wdata,
    input  logic [WIDTH-1:0]  mem_rdata,
    output logic              done
);

    localparam int unsigned IW = bsort_pkg::idx_bits(COUNT);

    logic              out_of_order;
    logic              wr_active;
    logic              cap_en;
    logic              swap_en;
    logic [IW-1:0]     cap_idx;
    logic [IW-1:0]     cmp_idx;
    logic [IW-1:0]     wr_idx;
    logic [WIDTH-1:0]  lo_val;
    logic [WIDTH-1:0]  hi_val;
    logic [WIDTH-1:0]  rd_val;
    logic [ADDR_W-1:0] addr;

    bsort_sequencer #(.COUNT(COUNT), .ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .out_of_order (out_of_order),
        .addr         (addr),
        .wr_active    (wr_active),
        .cap_en       (cap_en),
        .cap_idx      (cap_idx),
        .cmp_idx      (cmp_idx),
        .wr_idx       (wr_idx),
        .swap_en      (swap_en),
        .done         (done)
    );

    bsort_regfile #(.COUNT(COUNT), .WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_data (mem_rdata),
        .swap_en  (swap_en),
        .swap_idx (cmp_idx),
        .rd_idx   (wr_idx),
        .lo_val   (lo_val),
        .hi_val   (hi_val),
        .rd_val   (rd_val)
    );

    bsort_compare #(.WIDTH(WIDTH)) u_cmp (
        .lo_val       (lo_val),
        .hi_val       (hi_val),
        .out_of_order (out_of_order)
    );

    assign mem_en    = 1'b1;
    assign mem_we    = wr_active;
    assign mem_addr  = addr;
    assign mem_wdata = rd_val;

    // write enable is only ever raised together with the write-back address range
    assert_we_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr < ADDR_W'(COUNT)) && !done);

endmodule

// File: tb/bubble_sort_engine_tb.sv
`timescale 1ns/1ps
module bubble_sort_engine_tb;

    localparam int N  = 16;
    localparam int W  = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mem_en, mem_we, done;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bubble_sort_engine #(.COUNT(N), .WIDTH(W), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
    );

    // single-port RAM model, read-first, one-cycle read latency
    logic [W-1:0] ram [0:(1<<AW)-1];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard of expected write-back items
    typedef struct { logic [AW-1:0] a; logic [W-1:0] d; } item_t;
    item_t exp_q[$];

    always @(negedge clk) begin : monitor
        item_t it;
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "write with empty scoreboard", int'(mem_addr), -1);
            end else begin
                it = exp_q.pop_front();
                check(mem_addr == it.a, "R5", "write-back address", int'(mem_addr), int'(it.a));
                check(mem_wdata == it.d, "R4", "write-back value", int'(mem_wdata), int'(it.d));
            end
        end
    end

    logic [W-1:0] vin [N];

    task automatic run_block(input bit by_reset, input bit poke, input string tag);
        logic [W-1:0] s [N];
        logic [W-1:0] t;
        int comps, c, expc;
        bit sw;
        for (int k = 0; k < N; k++) begin s[k] = vin[k]; ram[k] = vin[k]; end
        ram[N] = 8'h5A;
        comps = 0;
        for (int p = 0; p < N-1; p++) begin
            sw = 0;
            for (int j = 0; j < N-1-p; j++) begin
                comps++;
                if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; sw = 1; end
            end
            if (!sw) break;
        end
        expc = (N+1) + comps + N;
        for (int k = 0; k < N; k++) exp_q.push_back('{a: AW'(k), d: s[k]});

        if (by_reset) begin
            rst = 1'b1;
            repeat (3) @(negedge clk);
            check(mem_addr == 0 && mem_en && !mem_we && !done, "R1", {tag, " state in reset"},
                  int'({mem_en, mem_we, done}), 4);
            rst = 1'b0;
            check(mem_addr == 0 && mem_en && !mem_we && !done, "R1", {tag, " first cycle"},
                  int'(mem_addr), 0);
        end else begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            check(!done && mem_addr == 0 && !mem_we, "R9", {tag, " restart cycle"},
                  int'({done, mem_addr}), 0);
        end

        c = 0;
        while (!done && c < 1000) begin
            @(negedge clk);
            c++;
            if (c < N) check(mem_addr == AW'(c), "R2", {tag, " load address"}, int'(mem_addr), c);
            if (c < N + 1 + comps) check(!mem_we, "R6", {tag, " we low before write-back"}, int'(mem_we), 0);
            if (poke && c == 20) start = 1'b1;
            if (poke && c == 21) start = 1'b0;
        end
        check(c == expc, "R7", {tag, " cycles to done"}, c, expc);
        check(exp_q.size() == 0, "R5", {tag, " writes outstanding"}, exp_q.size(), 0);
        exp_q.delete();
        for (int k = 0; k < N; k++)
            check(ram[k] == s[k], "R4", {tag, " RAM contents"}, int'(ram[k]), int'(s[k]));
        check(ram[N] == 8'h5A, "R6", {tag, " word past block untouched"}, int'(ram[N]), 'h5A);
        repeat (4) begin
            @(negedge clk);
            check(done && !mem_we, "R8", {tag, " done held"}, int'({done, mem_we}), 2);
        end
    endtask

    initial begin : main
        for (int k = 0; k < (1<<AW); k++) ram[k] = 8'(k ^ 8'h3C);

        // R3 R4: mixed values with high bit set, entered from reset
        for (int k = 0; k < N; k++) vin[k] = 8'(k*167 + 29);
        run_block(1'b1, 1'b0, "mixed");

        // R7: already ascending, one pass
        for (int k = 0; k < N; k++) vin[k] = 8'(k*3 + 1);
        run_block(1'b0, 1'b0, "ascending");

        // R7: strictly descending, all fifteen passes
        for (int k = 0; k < N; k++) vin[k] = 8'(255 - k*17);
        run_block(1'b0, 1'b0, "descending");

        // R10 R8: all equal, with a start pulse mid-sort that must be ignored
        for (int k = 0; k < N; k++) vin[k] = 8'h80;
        run_block(1'b0, 1'b1, "equal");

        // R4: extremes and duplicates around the sign boundary
        for (int k = 0; k < N; k++)
            vin[k] = (k % 4 == 0) ? 8'hFF : (k % 4 == 1) ? 8'h00 : (k % 3 == 0) ? 8'h7F : 8'h80;
        run_block(1'b0, 1'b0, "extremes");

        // R1: reset applied in the middle of a run
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (25) @(negedge clk);
        for (int k = 0; k < N; k++) vin[k] = 8'(200 - k*11 + (k % 2) * 90);
        run_block(1'b1, 1'b0, "midreset");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule